// File: doc/BRIEF.md
# Shift, Rotate and Bit-Manipulation Unit

This block carries out the prefixed byte operations of an 8-bit processor core: four rotate forms (circular or through the carry, in either direction), three shifts (left, arithmetic right and logical right), the nibble exchange, and single-bit test, set and clear. Each operation produces a result byte, a new set of condition flags and the write enables that tell the surrounding core what to commit. Opcode decoding happens upstream. The core hands over an operation code, a bit index, the operand, the current flags and a marker for the short accumulator-only rotate encodings.

An operand comes either from a register or from memory. For a register operand the block answers one cycle after the launch. For a memory operand a small sequencer runs a read-modify-write. In the first phase it signals busy and captures the byte on the read data input. In the second phase it drives the computed byte with a single-cycle write strobe. The flags are delivered after the write. A bit test on memory reads the byte and never writes it back.

Top module: `bitops_unit`

## Requirements
- R1: Op code 0 (circular left) moves operand bit 7 into result bit 0 and into carry. Op code 1 (circular right) moves bit 0 into result bit 7 and into carry.
- R2: Op code 2 (left through carry) puts the incoming carry into bit 0 and moves bit 7 into carry. Op code 3 (right through carry) puts the incoming carry into bit 7 and moves bit 0 into carry.
- R3: Op code 4 shifts left, fills bit 0 with 0 and moves bit 7 into carry. Op code 5 shifts right, keeps bit 7 and moves bit 0 into carry. Op code 6 shifts right, fills bit 7 with 0 and moves bit 0 into carry.
- R4: For op codes 0 to 7, the new flags have subtract and half-carry at 0 and zero set exactly when the result is 0. The flag vector is {zero, subtract, half, carry} on bits 3..0.
- R5: When acc_form is high, op codes 0 to 3 leave zero at 0 even for a zero result. For every other op code, acc_form has no effect.
- R6: Op code 7 exchanges the two nibbles and yields carry 0.
- R7: Op code 8 (bit test) sets zero when the operand bit chosen by bit_sel is 0 and clears zero otherwise. It sets half-carry, clears subtract and keeps the incoming carry. The result equals the operand, and no write enable is raised.
- R8: Op code 9 sets and op code 10 clears the bit chosen by bit_sel, changing no other bit. flags_we stays 0 and flags_out equals flags_in.
- R9: Op codes 11 to 15 return the operand unchanged, keep the flags, and raise none of flags_we, reg_we or mem_we.
- R10: With a register operand, done rises exactly one cycle after start, together with the result, the new flags, flags_we and reg_we. mem_we stays 0.
- R11: With a memory operand, busy is high for the single cycle after start, and the byte on mem_rdata is captured in that cycle. In the next cycle mem_we pulses once with the result on mem_wdata. done follows one cycle later with the flags, and reg_we stays 0.
- R12: A bit test on a memory operand raises no mem_we. done follows directly after the busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches an operation while idle |
| mem_op | input | 1 | Operand comes from memory (read-modify-write) |
| acc_form | input | 1 | Short accumulator rotate form: zero flag forced clear |
| op_code | input | 4 | Operation select, codes 0 to 10 |
| bit_sel | input | 3 | Bit index for test, set and clear |
| reg_data | input | 8 | Register operand, sampled with start |
| mem_rdata | input | 8 | Memory read data, sampled during busy |
| flags_in | input | 4 | Incoming flags {zero, subtract, half, carry} |
| busy | output | 1 | Memory read phase in progress |
| mem_we | output | 1 | Single-cycle memory write strobe |
| mem_wdata | output | 8 | Byte written back to memory |
| done | output | 1 | Result and flags valid this cycle |
| result | output | 8 | Result byte |
| flags_out | output | 4 | New flags {zero, subtract, half, carry} |
| flags_we | output | 1 | Flags are to be committed |
| reg_we | output | 1 | Result is to be written to the register |

## Verification
The rotates are tried with operands whose moving end bit is 1 and then 0, with the incoming carry both set and clear, so that circular rotation can be told apart from rotation through the carry. Results that come out as zero are run with the accumulator form on and off, which separates the real zero flag from the forced-clear one. The arithmetic and logical right shifts use an operand with bit 7 set, the only case in which they differ. The test, set and clear operations walk every bit index over all-zero and all-one bytes. The same operations are repeated on memory operands so that the strobe order and the missing write on a bit test show up.

// File: rtl/bitops_pkg.sv
package bitops_pkg;

   typedef enum logic [3:0] {
      OP_ROL_C  = 4'd0,
      OP_ROR_C  = 4'd1,
      OP_ROL_T  = 4'd2,
      OP_ROR_T  = 4'd3,
      OP_SHL    = 4'd4,
      OP_SHR_A  = 4'd5,
      OP_SHR_L  = 4'd6,
      OP_NIBX   = 4'd7,
      OP_BTEST  = 4'd8,
      OP_BSET   = 4'd9,
      OP_BCLR   = 4'd10
   } bop_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_FETCH = 2'd1,
      SQ_STORE = 2'd2,
      SQ_DONE  = 2'd3
   } seq_e;

   localparam int FLG_W = 4;
   localparam int FZ    = 3;
   localparam int FN    = 2;
   localparam int FH    = 1;
   localparam int FC    = 0;

endpackage

// File: rtl/bitops_shift.sv
module bitops_shift
   import bitops_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [3:0]       kind,
   input  logic [WIDTH-1:0] opnd,
   input  logic             cin,
   output logic [WIDTH-1:0] res,
   output logic             cout
);
   localparam int HALF = WIDTH / 2;

   logic [WIDTH-1:0] nib_x;

   generate
      if (WIDTH < 2 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("bitops_shift: WIDTH must be even and at least 2");
      end
      for (genvar i = 0; i < HALF; i++) begin : g_nibx
         assign nib_x[i]        = opnd[i + HALF];
         assign nib_x[i + HALF] = opnd[i];
      end
   endgenerate

   always_comb begin
      res  = opnd;
      cout = 1'b0;
      case (bop_e'(kind))
         OP_ROL_C: begin res = {opnd[WIDTH-2:0], opnd[WIDTH-1]}; cout = opnd[WIDTH-1]; end
         OP_ROR_C: begin res = {opnd[0], opnd[WIDTH-1:1]};       cout = opnd[0];       end
         OP_ROL_T: begin res = {opnd[WIDTH-2:0], cin};           cout = opnd[WIDTH-1]; end
         OP_ROR_T: begin res = {cin, opnd[WIDTH-1:1]};           cout = opnd[0];       end
         OP_SHL:   begin res = {opnd[WIDTH-2:0], 1'b0};          cout = opnd[WIDTH-1]; end
         OP_SHR_A: begin res = {opnd[WIDTH-1], opnd[WIDTH-1:1]}; cout = opnd[0];       end
         OP_SHR_L: begin res = {1'b0, opnd[WIDTH-1:1]};          cout = opnd[0];       end
         OP_NIBX:  begin res = nib_x;                            cout = 1'b0;          end
         default:  begin res = opnd;                             cout = 1'b0;          end
      endcase
   end

endmodule

// File: rtl/bitops_bitfield.sv
module bitops_bitfield
   import bitops_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int IDX_W = $clog2(WIDTH)
) (
   input  logic [3:0]       kind,
   input  logic [IDX_W-1:0] idx,
   input  logic [WIDTH-1:0] opnd,
   output logic [WIDTH-1:0] res,
   output logic             picked
);
   logic [WIDTH-1:0] mask;

   always_comb begin
      mask   = '0;
      mask[idx] = 1'b1;
      picked = opnd[idx];
      case (bop_e'(kind))
         OP_BSET: res = opnd | mask;
         OP_BCLR: res = opnd & ~mask;
         default: res = opnd;
      endcase
   end

endmodule

// File: rtl/bitops_seq.sv
module bitops_seq
   import bitops_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mem_op,
   input  logic need_wr,
   output logic launch,
   output logic fetch,
   output logic store,
   output logic fin
);
   seq_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         SQ_IDLE:  if (start) st_d = mem_op ? SQ_FETCH : SQ_DONE;
         SQ_FETCH: st_d = need_wr ? SQ_STORE : SQ_DONE;
         SQ_STORE: st_d = SQ_DONE;
         default:  st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_d;
   end

   assign launch = (st_q == SQ_IDLE) && start;
   assign fetch  = (st_q == SQ_FETCH);
   assign store  = (st_q == SQ_STORE);
   assign fin    = (st_q == SQ_DONE);

   // R11: the write strobe lasts one cycle and is followed by done
   a_r11_store_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      store |=> (fin && !store));
   // R11: the read phase lasts a single cycle
   a_r11_fetch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |=> !fetch);
   // R10: done is a single-cycle pulse
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);

endmodule

// File: rtl/bitops_unit.sv
module bitops_unit
   import bitops_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int IDX_W = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             mem_op,
   input  logic             acc_form,
   input  logic [3:0]       op_code,
   input  logic [IDX_W-1:0] bit_sel,
   input  logic [WIDTH-1:0] reg_data,
   input  logic [WIDTH-1:0] mem_rdata,
   input  logic [FLG_W-1:0] flags_in,
   output logic             busy,
   output logic             mem_we,
   output logic [WIDTH-1:0] mem_wdata,
   output logic             done,
   output logic [WIDTH-1:0] result,
   output logic [FLG_W-1:0] flags_out,
   output logic             flags_we,
   output logic             reg_we
);
   logic [3:0]       op_q;
   logic [IDX_W-1:0] idx_q;
   logic             acc_q;
   logic             mem_q;
   logic [FLG_W-1:0] flg_q;
   logic [WIDTH-1:0] opnd_q;

   logic             launch, fetch, store, fin;
   logic             is_rot, is_shgrp, is_test, is_bitwr, wr_res, upd_flg;
   logic [WIDTH-1:0] sh_res, bf_res, calc_res;
   logic             sh_c, bf_bit;
   logic [FLG_W-1:0] calc_flg;

   assign is_rot   = (op_q <= 4'd3);
   assign is_shgrp = (op_q <= 4'd7);
   assign is_test  = (op_q == OP_BTEST);
   assign is_bitwr = (op_q == OP_BSET) || (op_q == OP_BCLR);
   assign wr_res   = is_shgrp || is_bitwr;
   assign upd_flg  = is_shgrp || is_test;

   bitops_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .mem_op  (mem_op),
      .need_wr (wr_res),
      .launch  (launch),
      .fetch   (fetch),
      .store   (store),
      .fin     (fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= '0;
         idx_q  <= '0;
         acc_q  <= 1'b0;
         mem_q  <= 1'b0;
         flg_q  <= '0;
         opnd_q <= '0;
      end else if (launch) begin
         op_q   <= op_code;
         idx_q  <= bit_sel;
         acc_q  <= acc_form;
         mem_q  <= mem_op;
         flg_q  <= flags_in;
         opnd_q <= reg_data;
      end else if (fetch) begin
         opnd_q <= mem_rdata;
      end
   end

   bitops_shift #(.WIDTH(WIDTH)) u_shift (
      .kind (op_q),
      .opnd (opnd_q),
      .cin  (flg_q[FC]),
      .res  (sh_res),
      .cout (sh_c)
   );

   bitops_bitfield #(.WIDTH(WIDTH)) u_bitf (
      .kind   (op_q),
      .idx    (idx_q),
      .opnd   (opnd_q),
      .res    (bf_res),
      .picked (bf_bit)
   );

   always_comb begin
      calc_res = is_shgrp ? sh_res : bf_res;
      calc_flg = flg_q;
      if (is_shgrp) begin
         calc_flg      = '0;
         calc_flg[FC]  = sh_c;
         calc_flg[FZ]  = (sh_res == '0) && !(acc_q && is_rot);
      end else if (is_test) begin
         calc_flg[FZ]  = !bf_bit;
         calc_flg[FN]  = 1'b0;
         calc_flg[FH]  = 1'b1;
      end
   end

   assign busy      = fetch;
   assign mem_we    = store;
   assign mem_wdata = calc_res;
   assign done      = fin;
   assign result    = calc_res;
   assign flags_out = calc_flg;
   assign flags_we  = fin && upd_flg;
   assign reg_we    = fin && !mem_q && wr_res;

   // R5: accumulator-form rotates never report zero
   a_r5_acc_rot_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && acc_q && is_rot) |-> !flags_out[FZ]);
   // R7: bit test keeps the carry it was given and writes nothing
   a_r7_test_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_test) |-> (flags_out[FC] == flg_q[FC] && !reg_we && result == opnd_q));
   // R8: set/clear touches at most one bit and no flags
   a_r8_one_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_bitwr) |-> ($countones(result ^ opnd_q) <= 1 && !flags_we));
   // R12: a memory bit test never reaches the write phase
   a_r12_test_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && is_test) |=> !mem_we);
   // R10: a register operand never strobes memory
   a_r10_reg_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mem_q) |-> $past(!mem_we));

endmodule

// File: tb/test_bitops_unit.sv
`timescale 1ns/1ps
module test_bitops_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, mem_op = 1'b0, acc_form = 1'b0;
   logic [3:0] op_code = '0;
   logic [2:0] bit_sel = '0;
   logic [7:0] reg_data = '0, mem_rdata = '0;
   logic [3:0] flags_in = '0;
   logic       busy, mem_we, done, flags_we, reg_we;
   logic [7:0] mem_wdata, result;
   logic [3:0] flags_out;

   always #10 clk = ~clk;

   bitops_unit i_bitops_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_op(mem_op), .acc_form(acc_form),
      .op_code(op_code), .bit_sel(bit_sel), .reg_data(reg_data), .mem_rdata(mem_rdata),
      .flags_in(flags_in), .busy(busy), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .done(done), .result(result), .flags_out(flags_out), .flags_we(flags_we),
      .reg_we(reg_we)
   );

   typedef struct {
      logic [7:0] res;
      logic [3:0] flg;
      logic       fwe;
      logic       rwe;
      logic       mwe;
      string      req;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0, n_bad = 0, seen_we = 0;
   bit   finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Independent model written from the requirements; flags {Z,N,H,C}
   task automatic model(input logic [3:0] op, input logic [2:0] b, input logic acc,
                        input logic [7:0] d, input logic [3:0] f,
                        output logic [7:0] r, output logic [3:0] fo,
                        output logic fwe, output logic wr);
      logic c;
      c = 1'b0; r = d; fo = f; fwe = 1'b0; wr = 1'b0;
      case (op)
         4'd0: begin c = d[7]; r = (d << 1) | {7'd0, d[7]}; end
         4'd1: begin c = d[0]; r = (d >> 1) | {d[0], 7'd0}; end
         4'd2: begin c = d[7]; r = (d << 1) | {7'd0, f[0]}; end
         4'd3: begin c = d[0]; r = (d >> 1) | {f[0], 7'd0}; end
         4'd4: begin c = d[7]; r = d << 1; end
         4'd5: begin c = d[0]; r = (d >> 1) | (d & 8'h80); end
         4'd6: begin c = d[0]; r = d >> 1; end
         4'd7: begin c = 1'b0; r = {d[3:0], d[7:4]}; end
         default: ;
      endcase
      if (op <= 4'd7) begin
         fo  = {(r == 8'h00) && !(acc && op <= 4'd3), 1'b0, 1'b0, c};
         fwe = 1'b1; wr = 1'b1;
      end else if (op == 4'd8) begin
         fo  = {~d[b], 1'b0, 1'b1, f[0]};
         fwe = 1'b1;
      end else if (op == 4'd9) begin
         r = d | (8'h01 << b); wr = 1'b1;
      end else if (op == 4'd10) begin
         r = d & ~(8'h01 << b); wr = 1'b1;
      end
   endtask

   // Driver: pushes the expected item, launches, waits for done
   task automatic issue(input string req, input logic [3:0] op, input logic [2:0] b,
                        input logic mem, input logic acc, input logic [7:0] d,
                        input logic [3:0] f);
      exp_t e;
      logic wr;
      model(op, b, acc, d, f, e.res, e.flg, e.fwe, wr);
      e.rwe = wr && !mem;
      e.mwe = wr && mem;
      e.req = req;
      q.push_back(e);
      @(negedge clk);
      start = 1'b1; op_code = op; bit_sel = b; mem_op = mem; acc_form = acc;
      flags_in = f;
      reg_data  = mem ? ~d : d;
      mem_rdata = mem ? d : ~d;
      @(negedge clk);
      start = 1'b0; reg_data = 8'h5A; flags_in = ~f;
      if (mem) begin
         check(busy == 1'b1, "R11", "busy in read phase", busy, 1);
         check(done == 1'b0, "R11", "done during read phase", done, 0);
         @(negedge clk);
         mem_rdata = 8'hC3;
      end else begin
         check(done == 1'b1, "R10", "done one cycle after start", done, 1);
      end
      for (int k = 0; k < 4 && !done; k++) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor: compares outputs against the queue as they appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            seen_we++;
            if (q.size() > 0)
               check(mem_wdata == q[0].res, q[0].req, "mem_wdata", mem_wdata, q[0].res);
         end
         if (done) begin
            if (q.size() == 0) begin
               check(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(result == e.res, e.req, "result", result, e.res);
               if (e.fwe)
                  check(flags_out == e.flg, e.req, "flags_out", flags_out, e.flg);
               check(flags_we == e.fwe, e.req, "flags_we", flags_we, e.fwe);
               check(reg_we == e.rwe, e.req, "reg_we", reg_we, e.rwe);
               check(seen_we == int'(e.mwe), e.req, "mem_we strobes", seen_we, e.mwe);
            end
            seen_we = 0;
         end
      end
   end

   initial begin
      #(20 * 100000);
      if (!finished) begin
         check(1'b0, "WATCHDOG", "run timed out", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0 && done == 0 && mem_we == 0, "R10", "idle after reset",
            {busy, done, mem_we}, 0);

      // R1 circular rotates
      issue("R1", 4'd0, 0, 0, 0, 8'h85, 4'h0);
      issue("R1", 4'd1, 0, 0, 0, 8'h01, 4'h0);
      issue("R1", 4'd0, 0, 0, 0, 8'h00, 4'h1);
      // R2 rotates through carry
      issue("R2", 4'd2, 0, 0, 0, 8'h80, 4'h0);
      issue("R2", 4'd2, 0, 0, 0, 8'h40, 4'h1);
      issue("R2", 4'd3, 0, 0, 0, 8'h01, 4'h1);
      issue("R2", 4'd3, 0, 0, 0, 8'h02, 4'h0);
      // R3 shifts
      issue("R3", 4'd4, 0, 0, 0, 8'h81, 4'h0);
      issue("R3", 4'd5, 0, 0, 0, 8'h81, 4'h0);
      issue("R3", 4'd6, 0, 0, 0, 8'h81, 4'h0);
      // R4 flags cleared, zero on zero result
      issue("R4", 4'd6, 0, 0, 0, 8'h01, 4'hE);
      issue("R4", 4'd4, 0, 0, 0, 8'h3C, 4'hF);
      // R5 accumulator form
      issue("R5", 4'd0, 0, 0, 1, 8'h00, 4'h0);
      issue("R5", 4'd3, 0, 0, 1, 8'h01, 4'h0);
      issue("R5", 4'd4, 0, 0, 1, 8'h80, 4'h0);
      issue("R5", 4'd7, 0, 0, 1, 8'h00, 4'h0);
      // R6 nibble exchange
      issue("R6", 4'd7, 0, 0, 0, 8'hA5, 4'h1);
      issue("R6", 4'd7, 0, 0, 0, 8'hF0, 4'h0);
      // R7 / R8 over every bit index
      for (int b = 0; b < 8; b++) begin
         issue("R7", 4'd8, b[2:0], 0, 0, 8'hFF, 4'h1);
         issue("R7", 4'd8, b[2:0], 0, 0, 8'h00, 4'h0);
         issue("R8", 4'd9, b[2:0], 0, 0, 8'h00, 4'hA);
         issue("R8", 4'd10, b[2:0], 0, 0, 8'hFF, 4'h5);
      end
      // R9 unused codes
      issue("R9", 4'd11, 3, 0, 0, 8'h6E, 4'h9);
      issue("R9", 4'd15, 3, 1, 0, 8'h6E, 4'h9);
      // R11 memory read-modify-write
      issue("R11", 4'd0, 0, 1, 0, 8'h80, 4'h0);
      issue("R11", 4'd7, 0, 1, 0, 8'h12, 4'h0);
      issue("R11", 4'd9, 7, 1, 0, 8'h01, 4'h3);
      issue("R11", 4'd3, 0, 1, 0, 8'h01, 4'h1);
      // R12 memory bit test
      issue("R12", 4'd8, 4, 1, 0, 8'hEF, 4'h1);
      issue("R12", 4'd8, 4, 1, 0, 8'h10, 4'h0);

      check(q.size() == 0, "R10", "all results delivered", q.size(), 0);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule